// File: doc/BRIEF.md
# Latched Interrupt Controller with Write-Message Delivery

This block collects eleven level-sensitive interrupt lines. It keeps a live copy of their levels and a sticky record of lines that have newly gone high. Each line has an enable bit and a route bit. When an enabled line rises from a state that was not already latched, the block posts a single-beat memory-write message to one of two programmable targets. The route bit selects which target is used. Both the destination address and the payload of the message come from that one target value. The address is the value with its five low bits cleared, and the payload is those five bits.

Software reaches the state through a small register port. The port gives access to the live levels, the sticky pending record, the enable and route masks, and the two targets. It also provides two computed views that show which live, enabled lines are routed to each target. Reading the pending record returns its contents and then empties it, and a write of any value empties it as well. By convention, lines 0 to 5 carry the bus interrupt pins A to F, line 6 carries an external interrupt, line 7 carries a non-fatal bus error, line 8 carries the keyboard/mouse port, line 9 is spare, and line 10 carries the serial port.

When several lines rise in the same cycle, their messages wait in a queue. They leave one per valid/ready handshake, lowest line number first.

Top module: `irq_msg_ctrl`

## Requirements
- R1: The level register (select 0) equals the value of `irq_in` sampled at the previous clock edge. It is read-only: writes to it leave it unchanged.
- R2: A pending bit (select 1) is set only when its input is high and its level bit is low, that is, on a 0-to-1 change. A line held high does not set it again after it has been cleared.
- R3: A read of select 1 returns the pending bits and then clears them. A write of any value to select 1 also clears them. An edge arriving in the same cycle as the clear stays pending.
- R4: The enable mask (select 2) gates message delivery. An edge on a disabled line still sets its pending bit but posts no message.
- R5: The route mask (select 3) picks the target for a line's message: target 1 (select 5) if the bit is 1, target 0 (select 4) if it is 0.
- R6: The message address is the target value with bits 4:0 cleared. The message data is the target's bits 4:0 as a big-endian 32-bit word: the lowest-address byte sits in bits 31:24, so the numeric value equals bits 4:0 zero-extended.
- R7: The request-0 view (select 6) reads level & enable & ~route, and the request-1 view (select 7) reads level & enable & route. Both are read-only.
- R8: After reset both targets read 0xFFFB0003. The level, pending, enable and route registers read 0, and no message is offered.
- R9: Edges on several enabled lines in one cycle post one message per line, lowest line first. `msg_valid` and the message stay up until `msg_ready` is high at a clock edge.
- R10: The enable and route registers hold only the low 11 bits. Written bits above them read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 11 | Level-sensitive interrupt lines |
| reg_sel | input | 3 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on pending) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from select |
| msg_valid | output | 1 | A write message is offered |
| msg_ready | input | 1 | The message is taken at this edge |
| msg_addr | output | 32 | Message address, 32-byte aligned |
| msg_data | output | 32 | Message payload word, big-endian |

## Verification
The checker tests several rules on every clock cycle:
- the level register tracks the input lines;
- a fresh edge always lands in the pending record;
- a pending clear leaves only the edges of that same cycle;
- an offered message holds until it is taken;
- the address is aligned;
- at most one queued line is granted.

Other behaviour can be shown only by the bench's scenarios. These include the routing choice between the two targets, the payload value, the lowest-first ordering of simultaneous edges, the masking of disabled lines, the computed request views, and the ignored writes to read-only registers.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;

    localparam int WORD_W = 32;
    localparam int SEL_W  = 3;
    localparam int LOW_W  = 5;

    typedef enum logic [SEL_W-1:0] {
        SEL_LEVEL = 3'd0,
        SEL_PEND  = 3'd1,
        SEL_MASK  = 3'd2,
        SEL_ROUTE = 3'd3,
        SEL_TGT0  = 3'd4,
        SEL_TGT1  = 3'd5,
        SEL_REQ0  = 3'd6,
        SEL_REQ1  = 3'd7
    } reg_sel_e;

    localparam logic [WORD_W-1:0] TGT_RESET = 32'hFFFB_0003;

    typedef struct packed {
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } wr_msg_t;

    // Split a target word into aligned address and big-endian payload word.
    function automatic wr_msg_t build_msg(input logic [WORD_W-1:0] tgt);
        wr_msg_t m;
        m.addr = {tgt[WORD_W-1:LOW_W], {LOW_W{1'b0}}};
        m.data = {{(WORD_W-LOW_W){1'b0}}, tgt[LOW_W-1:0]};
        return m;
    endfunction

endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
    parameter int N = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] irq_in,
    input  logic         clr_pend,
    output logic [N-1:0] lvl_q,
    output logic [N-1:0] pend_q,
    output logic [N-1:0] new_edge
);
    assign new_edge = irq_in & ~lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q  <= '0;
            pend_q <= '0;
        end else begin
            lvl_q  <= irq_in;
            pend_q <= (clr_pend ? '0 : pend_q) | new_edge;
        end
    end
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
    import irq_msg_pkg::*;
#(
    parameter int N = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic              reg_wr,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic [N-1:0]      lvl,
    input  logic [N-1:0]      pend,
    output logic [N-1:0]      mask_q,
    output logic [N-1:0]      route_q,
    output logic [WORD_W-1:0] tgt0_q,
    output logic [WORD_W-1:0] tgt1_q,
    output logic [WORD_W-1:0] reg_rdata
);
    localparam int PAD = WORD_W - N;

    reg_sel_e     sel;
    logic [N-1:0] req0, req1;

    assign sel  = reg_sel_e'(reg_sel);
    assign req0 = lvl & mask_q & ~route_q;
    assign req1 = lvl & mask_q & route_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '0;
            route_q <= '0;
            tgt0_q  <= TGT_RESET;
            tgt1_q  <= TGT_RESET;
        end else if (reg_wr) begin
            case (sel)
                SEL_MASK:  mask_q  <= reg_wdata[N-1:0];
                SEL_ROUTE: route_q <= reg_wdata[N-1:0];
                SEL_TGT0:  tgt0_q  <= reg_wdata;
                SEL_TGT1:  tgt1_q  <= reg_wdata;
                default:   ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_LEVEL: reg_rdata = {{PAD{1'b0}}, lvl};
            SEL_PEND:  reg_rdata = {{PAD{1'b0}}, pend};
            SEL_MASK:  reg_rdata = {{PAD{1'b0}}, mask_q};
            SEL_ROUTE: reg_rdata = {{PAD{1'b0}}, route_q};
            SEL_TGT0:  reg_rdata = tgt0_q;
            SEL_TGT1:  reg_rdata = tgt1_q;
            SEL_REQ0:  reg_rdata = {{PAD{1'b0}}, req0};
            default:   reg_rdata = {{PAD{1'b0}}, req1};
        endcase
    end
endmodule

// File: rtl/irq_msg_queue.sv
module irq_msg_queue
    import irq_msg_pkg::*;
#(
    parameter int N = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      fire,
    input  logic [N-1:0]      route,
    input  logic [WORD_W-1:0] tgt0,
    input  logic [WORD_W-1:0] tgt1,
    input  logic              msg_ready,
    output logic              msg_valid,
    output wr_msg_t           msg,
    output logic [N-1:0]      grant
);
    localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

    logic [N-1:0] q_bits, q_route, taken;
    logic         use_t1;

    // Lowest set bit wins.
    assign grant     = q_bits & (~q_bits + ONE);
    assign msg_valid = |q_bits;
    assign use_t1    = |(grant & q_route);
    assign msg       = build_msg(use_t1 ? tgt1 : tgt0);
    assign taken     = (msg_valid && msg_ready) ? grant : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_bits  <= '0;
            q_route <= '0;
        end else begin
            q_bits  <= (q_bits & ~taken) | fire;
            q_route <= (q_route & ~fire) | (route & fire);
        end
    end
endmodule

// File: rtl/irq_msg_ctrl.sv
module irq_msg_ctrl
    import irq_msg_pkg::*;
#(
    parameter int NUM_IRQ = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic [2:0]         reg_sel,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               msg_valid,
    input  logic               msg_ready,
    output logic [31:0]        msg_addr,
    output logic [31:0]        msg_data
);
    logic [NUM_IRQ-1:0] lvl, pend, new_edge, mask, route, grant;
    logic [WORD_W-1:0]  tgt0, tgt1;
    logic               clr_pend;
    wr_msg_t            msg;

    assign clr_pend = (reg_rd || reg_wr) && (reg_sel == SEL_PEND);

    irq_edge_latch #(.N(NUM_IRQ)) u_latch (
        .clk(clk), .rst(rst), .irq_in(irq_in), .clr_pend(clr_pend),
        .lvl_q(lvl), .pend_q(pend), .new_edge(new_edge)
    );

    irq_regfile #(.N(NUM_IRQ)) u_regs (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .lvl(lvl), .pend(pend),
        .mask_q(mask), .route_q(route), .tgt0_q(tgt0), .tgt1_q(tgt1),
        .reg_rdata(reg_rdata)
    );

    irq_msg_queue #(.N(NUM_IRQ)) u_queue (
        .clk(clk), .rst(rst), .fire(new_edge & mask), .route(route),
        .tgt0(tgt0), .tgt1(tgt1), .msg_ready(msg_ready),
        .msg_valid(msg_valid), .msg(msg), .grant(grant)
    );

    assign msg_addr = msg.addr;
    assign msg_data = msg.data;
endmodule

// File: rtl/irq_msg_ctrl_chk.sv
module irq_msg_ctrl_chk #(
    parameter int N = 11
) (
    input logic         clk,
    input logic         rst,
    input logic [N-1:0] irq_in,
    input logic [N-1:0] lvl,
    input logic [N-1:0] pend,
    input logic [N-1:0] grant,
    input logic         clr_pend,
    input logic         msg_valid,
    input logic         msg_ready,
    input logic [31:0]  msg_addr
);
    assert_level_follow_R1: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (lvl == $past(irq_in)));

    assert_edge_pends_R2: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((pend & $past(irq_in & ~lvl)) == $past(irq_in & ~lvl)));

    assert_clear_keeps_edge_R3: assert property (@(posedge clk) disable iff (rst)
        clr_pend |=> (pend == $past(irq_in & ~lvl)));

    assert_addr_aligned_R6: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> (msg_addr[4:0] == 5'd0));

    assert_msg_held_R9: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> msg_valid);

    assert_single_grant_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant) && (msg_valid == (grant != '0)));
endmodule

bind irq_msg_ctrl irq_msg_ctrl_chk #(.N(NUM_IRQ)) u_chk (
    .clk(clk), .rst(rst), .irq_in(irq_in), .lvl(lvl), .pend(pend),
    .grant(grant), .clr_pend(clr_pend), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_addr(msg_addr)
);

// File: tb/tb_irq_msg_ctrl.sv
module tb_irq_msg_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] irq_in = '0;
    logic [2:0]  reg_sel = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, msg_ready = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata, msg_addr, msg_data;
    logic        msg_valid;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irq_msg_ctrl dut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .reg_sel(reg_sel),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] sel, output logic [31:0] v);
        @(negedge clk);
        reg_sel = sel; reg_rd = 1'b1;
        #2 v = reg_rdata;
        @(posedge clk); #1 reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] v);
        @(negedge clk);
        reg_sel = sel; reg_wdata = v; reg_wr = 1'b1;
        @(posedge clk); #1 reg_wr = 1'b0;
    endtask

    task automatic set_irq(input logic [10:0] v);
        @(negedge clk); irq_in = v;
        @(posedge clk); #1;
    endtask

    task automatic take_msg(input string tag, input logic [31:0] ea, input logic [31:0] ed);
        @(negedge clk);
        check({tag, " valid"}, {31'd0, msg_valid}, 32'd1);
        check({tag, " addr"}, msg_addr, ea);
        check({tag, " data"}, msg_data, ed);
        msg_ready = 1'b1;
        @(posedge clk); #1 msg_ready = 1'b0;
    endtask

    task automatic no_msg(input string tag);
        @(negedge clk);
        check(tag, {31'd0, msg_valid}, 32'd0);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(3'd0, v); check("R8 level", v, 0);
        rd(3'd1, v); check("R8 pend", v, 0);
        rd(3'd2, v); check("R8 mask", v, 0);
        rd(3'd3, v); check("R8 route", v, 0);
        rd(3'd4, v); check("R8 tgt0", v, 32'hFFFB0003);
        rd(3'd5, v); check("R8 tgt1", v, 32'hFFFB0003);
        no_msg("R8 no message");
    endtask

    task automatic t_level_masked;
        logic [31:0] v;
        set_irq(11'h008);
        rd(3'd0, v); check("R1 level high", v, 32'h8);
        no_msg("R4 masked edge no message");
        set_irq(11'h000);
        rd(3'd0, v); check("R1 level low", v, 0);
        rd(3'd1, v); check("R2/R4 pend of masked edge", v, 32'h8);
        rd(3'd1, v); check("R3 read cleared", v, 0);
    endtask

    task automatic t_route;
        logic [31:0] v;
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd2, v); check("R10 mask width", v, 32'h7FF);
        wr(3'd3, 32'hFFFF_F020);
        rd(3'd3, v); check("R10 route width", v, 32'h020);
        wr(3'd3, 32'h0000_0120);
        wr(3'd4, 32'h1234_5678);
        wr(3'd5, 32'hABCD_EF1F);
        set_irq(11'h002);
        take_msg("R5/R6 route0", 32'h1234_5660, 32'h18);
        no_msg("R9 single message");
        set_irq(11'h000);
        set_irq(11'h020);
        take_msg("R5/R6 route1", 32'hABCD_EF00, 32'h1F);
        set_irq(11'h000);
        wr(3'd1, 32'h0);
    endtask

    task automatic t_order;
        logic [31:0] v;
        set_irq(11'h510);
        repeat (3) @(posedge clk);
        #1;
        take_msg("R9 first line4", 32'h1234_5660, 32'h18);
        take_msg("R9 second line8", 32'hABCD_EF00, 32'h1F);
        take_msg("R9 third line10", 32'h1234_5660, 32'h18);
        no_msg("R9 queue empty");
        rd(3'd6, v); check("R7 req0", v, 32'h410);
        rd(3'd7, v); check("R7 req1", v, 32'h100);
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd6, 32'hFFFF_FFFF);
        rd(3'd0, v); check("R1 level write ignored", v, 32'h510);
        rd(3'd6, v); check("R7 req0 write ignored", v, 32'h410);
        wr(3'd1, 32'h5A5A_5A5A);
        repeat (3) @(posedge clk);
        rd(3'd1, v); check("R2/R3 held line not re-pended", v, 0);
        no_msg("R2 held line no message");
        set_irq(11'h000);
    endtask

    task automatic t_clear_race;
        logic [31:0] v;
        wr(3'd2, 32'h0);
        set_irq(11'h040);
        @(negedge clk);
        irq_in = 11'h041; reg_sel = 3'd1; reg_rd = 1'b1;
        #2 v = reg_rdata;
        @(posedge clk); #1 reg_rd = 1'b0;
        check("R3 read value", v, 32'h40);
        rd(3'd1, v); check("R3 edge kept over clear", v, 32'h1);
        set_irq(11'h000);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_level_masked();
        t_route();
        t_order();
        t_clear_race();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R9 actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule